// File: doc/BRIEF.md
# Multi-width pixel write assembler

The block sits between a host parallel write bus and the write port of a pixel memory. The host sets the bus width with a 2-bit format code and, for the narrowest bus, a three-transfer select. The block then gathers one, two or three data transfers into one 18-bit pixel with 6 bits each of red, green and blue. An optional red/blue exchange is applied to the finished pixel. The pixel is then loaded into a write data register, which presents it to the memory with a one-cycle valid pulse. The host does nothing more after the last transfer.

A write with the data/command select low is an index or command write. It does not go through packing. Its low byte appears on a command output with its own one-cycle strobe. It also returns the packing sequence to the first transfer, so a new memory-write command always starts a pixel cleanly.

Packing is run by one phase machine with three states: `PH_FIRST`, `PH_SECOND` and `PH_THIRD`. It has three named transitions:
- ADVANCE moves one state on after a data transfer that does not complete a pixel.
- WRAP returns to `PH_FIRST` after the final transfer of a pixel.
- CMD_RESET returns to `PH_FIRST` on any command write.

The last phase depends on the mode: `PH_FIRST` for codes 00 and 01, `PH_SECOND` for code 10 and for code 11 with the select low, and `PH_THIRD` for code 11 with the select high.

Top module: `pix_pack_top`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, `pix_data`, `pix_valid`, `cmd_data` and `cmd_valid` are all zero.
- R2: Format code 00: each data write is one full pixel, and `pix_data` equals `bus_data[17:0]`. Red is in bits [17:12], green in [11:6] and blue in [5:0].
- R3: Format code 01: one data write makes one pixel from the 5-6-5 value in `bus_data[15:0]`. Red is [15:11], green is [10:5] and blue is [4:0]. Red and blue are widened to 6 bits by appending a copy of their own top bit as the new LSB.
- R4: Format code 10: two data writes make one pixel. `bus_data[8:0]` of the first write becomes pixel bits [17:9], and `bus_data[8:0]` of the second write becomes pixel bits [8:0].
- R5: Format code 11 with `tri_sel`=0: two data writes make one pixel. Byte `bus_data[7:0]` of the first write becomes pixel [17:10], and the byte of the second write becomes pixel [9:2]. Pixel [1:0] repeats pixel [5:4].
- R6: Format code 11 with `tri_sel`=1: three data writes make one pixel. In each write only `bus_data[7:2]` is used. The first write gives red, the second gives green and the third gives blue.
- R7: When `swap_rb` is high in the cycle of the final transfer, the stored pixel has its red and blue fields exchanged; green is unchanged.
- R8: `pix_valid` is high for exactly the one cycle after the clock edge that captures the final transfer of a pixel. Earlier transfers of a pixel give no pulse. `pix_data` holds its value until the next pixel completes.
- R9: A write with `bus_dc`=0 puts `bus_data[7:0]` on `cmd_data` and raises `cmd_valid` for one cycle. It raises no `pix_valid`.
- R10: A command write returns packing to the first transfer, so the next data write is treated as the first transfer of a new pixel.
- R11: Cycles with `bus_wr` low raise neither valid output and change neither `pix_data` nor `cmd_data`, whatever is on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe; one transfer per cycle it is high |
| bus_dc | input | 1 | 1 = pixel data transfer, 0 = command/index write |
| bus_data | input | 18 | Host bus data |
| fmt_sel | input | 2 | Bus format code (00 18-bit, 01 16-bit, 10 9-bit, 11 8-bit) |
| tri_sel | input | 1 | With format 11: 0 = two byte transfers, 1 = three 6-bit transfers |
| swap_rb | input | 1 | Exchange red and blue of the completed pixel |
| pix_data | output | 18 | Write data register toward pixel memory |
| pix_valid | output | 1 | One-cycle pulse when a new pixel is posted |
| cmd_data | output | 8 | Last command/index byte |
| cmd_valid | output | 1 | One-cycle pulse on a command write |

## Verification
The bench builds the block with its defaults: 6-bit colour channels and an 8-bit command byte. At this size every mode and every phase of the machine can be walked with dozens of arithmetic data patterns. These patterns reach both values of the replicated top bit in the 5-6-5 expansion and the repeated blue bits of the byte mode. They also cover interrupting a three-transfer pixel with a command, and the red/blue exchange in single- and multi-transfer modes.

// File: rtl/pix_pack_pkg.sv
package pix_pack_pkg;

    localparam int CHAN_W = 6;
    localparam int PIX_W  = 3 * CHAN_W;
    localparam int CMD_W  = 8;

    typedef enum logic [1:0] {
        FMT_BUS18 = 2'b00,
        FMT_BUS16 = 2'b01,
        FMT_BUS9  = 2'b10,
        FMT_BUS8  = 2'b11
    } fmt_e;

    typedef enum logic [1:0] {
        PH_FIRST  = 2'd0,
        PH_SECOND = 2'd1,
        PH_THIRD  = 2'd2
    } phase_e;

    // Index of the transfer that completes a pixel in each mode.
    function automatic logic [1:0] last_phase(input logic [1:0] fmt, input logic tri_mode);
        logic [1:0] lp;
        unique case (fmt_e'(fmt))
            FMT_BUS18: lp = 2'd0;
            FMT_BUS16: lp = 2'd0;
            FMT_BUS9:  lp = 2'd1;
            FMT_BUS8:  lp = tri_mode ? 2'd2 : 2'd1;
            default:   lp = 2'd0;
        endcase
        return lp;
    endfunction

endpackage

// File: rtl/pix_phase_fsm.sv
module pix_phase_fsm
    import pix_pack_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       data_wr,
    input  logic       cmd_wr,
    input  logic [1:0] fmt_sel,
    input  logic       tri_sel,
    output phase_e     phase,
    output logic       final_xfer
);

    phase_e     state_q;
    phase_e     state_d;
    logic [1:0] last_ph;
    logic       at_last;

    always_comb begin
        last_ph = last_phase(fmt_sel, tri_sel);
        at_last = (2'(state_q) >= last_ph);
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PH_FIRST;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: CMD_RESET, WRAP, ADVANCE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_FIRST: begin
                if (cmd_wr) begin
                    state_d = PH_FIRST;
                end else if (data_wr && !at_last) begin
                    state_d = PH_SECOND;
                end
            end
            PH_SECOND: begin
                if (cmd_wr) begin
                    state_d = PH_FIRST;
                end else if (data_wr) begin
                    state_d = at_last ? PH_FIRST : PH_THIRD;
                end
            end
            PH_THIRD: begin
                if (cmd_wr || data_wr) begin
                    state_d = PH_FIRST;
                end
            end
            default: state_d = PH_FIRST;
        endcase
    end

    // Outputs
    always_comb begin
        phase      = state_q;
        final_xfer = data_wr && at_last;
    end

endmodule

// File: rtl/pix_lane_merge.sv
module pix_lane_merge
    import pix_pack_pkg::*;
#(
    parameter int CW = CHAN_W
) (
    input  logic [1:0]      fmt_sel,
    input  logic            tri_sel,
    input  phase_e          phase,
    input  logic [3*CW-1:0] din,
    input  logic [3*CW-1:0] acc,
    output logic [3*CW-1:0] merged
);

    localparam int PW   = 3 * CW;
    localparam int HALF = PW / 2;
    localparam int BW   = 8;
    localparam int C5   = CW - 1;

    logic [C5-1:0] r_narrow;
    logic [CW-1:0] g_full;
    logic [C5-1:0] b_narrow;

    always_comb begin
        b_narrow = din[C5-1:0];
        g_full   = din[C5+CW-1:C5];
        r_narrow = din[2*C5+CW-1:C5+CW];
    end

    always_comb begin
        merged = acc;
        unique case (fmt_e'(fmt_sel))
            FMT_BUS18: merged = din;
            FMT_BUS16: merged = {r_narrow, r_narrow[C5-1], g_full, b_narrow, b_narrow[C5-1]};
            FMT_BUS9: begin
                if (phase == PH_FIRST) begin
                    merged[PW-1:HALF] = din[HALF-1:0];
                end else begin
                    merged[HALF-1:0] = din[HALF-1:0];
                end
            end
            FMT_BUS8: begin
                if (tri_sel) begin
                    unique case (phase)
                        PH_FIRST:  merged[3*CW-1:2*CW] = din[BW-1:BW-CW];
                        PH_SECOND: merged[2*CW-1:CW]   = din[BW-1:BW-CW];
                        default:   merged[CW-1:0]      = din[BW-1:BW-CW];
                    endcase
                end else if (phase == PH_FIRST) begin
                    merged[PW-1:PW-BW] = din[BW-1:0];
                end else begin
                    merged[PW-BW-1:0] = {din[BW-1:0], din[3:2]};
                end
            end
            default: merged = acc;
        endcase
    end

endmodule

// File: rtl/pix_wdr.sv
module pix_wdr
    import pix_pack_pkg::*;
#(
    parameter int CW   = CHAN_W,
    parameter int CMDW = CMD_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            data_wr,
    input  logic            cmd_wr,
    input  logic            final_xfer,
    input  logic            swap_rb,
    input  logic [3*CW-1:0] merged,
    input  logic [3*CW-1:0] din,
    output logic [3*CW-1:0] acc,
    output logic [3*CW-1:0] pix_data,
    output logic            pix_valid,
    output logic [CMDW-1:0] cmd_data,
    output logic            cmd_valid
);

    logic [3*CW-1:0] ordered;

    always_comb begin
        ordered = swap_rb ? {merged[CW-1:0], merged[2*CW-1:CW], merged[3*CW-1:2*CW]}
                          : merged;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc       <= '0;
            pix_data  <= '0;
            pix_valid <= 1'b0;
            cmd_data  <= '0;
            cmd_valid <= 1'b0;
        end else begin
            pix_valid <= final_xfer;
            cmd_valid <= cmd_wr;
            if (data_wr) begin
                acc <= merged;
            end
            if (final_xfer) begin
                pix_data <= ordered;
            end
            if (cmd_wr) begin
                cmd_data <= din[CMDW-1:0];
            end
        end
    end

endmodule

// File: rtl/pix_pack_top.sv
module pix_pack_top
    import pix_pack_pkg::*;
#(
    parameter int CW   = CHAN_W,
    parameter int CMDW = CMD_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_wr,
    input  logic            bus_dc,
    input  logic [3*CW-1:0] bus_data,
    input  logic [1:0]      fmt_sel,
    input  logic            tri_sel,
    input  logic            swap_rb,
    output logic [3*CW-1:0] pix_data,
    output logic            pix_valid,
    output logic [CMDW-1:0] cmd_data,
    output logic            cmd_valid
);

    localparam int PW = 3 * CW;

    logic          data_wr;
    logic          cmd_wr;
    logic          final_xfer;
    phase_e        phase;
    logic [PW-1:0] acc;
    logic [PW-1:0] merged;

    always_comb begin
        data_wr = bus_wr && bus_dc;
        cmd_wr  = bus_wr && !bus_dc;
    end

    pix_phase_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .data_wr    (data_wr),
        .cmd_wr     (cmd_wr),
        .fmt_sel    (fmt_sel),
        .tri_sel    (tri_sel),
        .phase      (phase),
        .final_xfer (final_xfer)
    );

    pix_lane_merge #(.CW(CW)) u_merge (
        .fmt_sel (fmt_sel),
        .tri_sel (tri_sel),
        .phase   (phase),
        .din     (bus_data),
        .acc     (acc),
        .merged  (merged)
    );

    pix_wdr #(.CW(CW), .CMDW(CMDW)) u_wdr (
        .clk        (clk),
        .rst_n      (rst_n),
        .data_wr    (data_wr),
        .cmd_wr     (cmd_wr),
        .final_xfer (final_xfer),
        .swap_rb    (swap_rb),
        .merged     (merged),
        .din        (bus_data),
        .acc        (acc),
        .pix_data   (pix_data),
        .pix_valid  (pix_valid),
        .cmd_data   (cmd_data),
        .cmd_valid  (cmd_valid)
    );

endmodule

// File: rtl/pix_pack_chk.sv
module pix_pack_chk #(
    parameter int CW   = 6,
    parameter int CMDW = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_wr,
    input logic            bus_dc,
    input logic [3*CW-1:0] bus_data,
    input logic [1:0]      fmt_sel,
    input logic            tri_sel,
    input logic            swap_rb,
    input logic [3*CW-1:0] pix_data,
    input logic            pix_valid,
    input logic [CMDW-1:0] cmd_data,
    input logic            cmd_valid
);

    // R8, R9: a pixel post and a command post never share a cycle
    assert_valid_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(pix_valid && cmd_valid));

    // R8: a pixel pulse is always caused by a data write one cycle earlier
    assert_pix_from_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> $past(bus_wr && bus_dc));

    // R9: command byte and strobe follow a command write
    assert_cmd_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_dc) |=> (cmd_valid && cmd_data == $past(bus_data[CMDW-1:0])));

    // R2: full-width mode posts every write directly
    assert_full_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_dc && fmt_sel == 2'b00 && !swap_rb) |=> (pix_valid && pix_data == $past(bus_data)));

    // R11: an idle cycle raises no pulse
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> (!pix_valid && !cmd_valid));

    // R8: the write data register holds between posts
    assert_wdr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |-> $stable(pix_data));

endmodule

bind pix_pack_top pix_pack_chk #(.CW(CW), .CMDW(CMDW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_dc    (bus_dc),
    .bus_data  (bus_data),
    .fmt_sel   (fmt_sel),
    .tri_sel   (tri_sel),
    .swap_rb   (swap_rb),
    .pix_data  (pix_data),
    .pix_valid (pix_valid),
    .cmd_data  (cmd_data),
    .cmd_valid (cmd_valid)
);

// File: tb/pix_pack_top_bench.sv
module pix_pack_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_dc = 1'b0;
    logic [17:0] bus_data = '0;
    logic [1:0]  fmt_sel = 2'b00;
    logic        tri_sel = 1'b0;
    logic        swap_rb = 1'b0;
    logic [17:0] pix_data;
    logic        pix_valid;
    logic [7:0]  cmd_data;
    logic        cmd_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pix_pack_top u_pix_pack_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_dc    (bus_dc),
        .bus_data  (bus_data),
        .fmt_sel   (fmt_sel),
        .tri_sel   (tri_sel),
        .swap_rb   (swap_rb),
        .pix_data  (pix_data),
        .pix_valid (pix_valid),
        .cmd_data  (cmd_data),
        .cmd_valid (cmd_valid)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic dc, input int d);
        @(negedge clk);
        bus_wr   = 1'b1;
        bus_dc   = dc;
        bus_data = 18'(d);
        @(posedge clk);
        #1;
        bus_wr = 1'b0;
    endtask

    function automatic int swap_exp(input int e);
        return ((e & 63) << 12) | (e & 'hFC0) | ((e >> 12) & 63);
    endfunction

    function automatic int exp565(input int v);
        int r5, g6, b5;
        r5 = (v >> 11) & 31;
        g6 = (v >> 5) & 63;
        b5 = v & 31;
        return ((r5 * 2 + (r5 >> 4)) * 4096) + g6 * 64 + (b5 * 2 + (b5 >> 4));
    endfunction

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int hold;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 pix_data", int'(pix_data), 0);
        chk("R1 pix_valid", int'(pix_valid), 0);
        chk("R1 cmd_data", int'(cmd_data), 0);
        chk("R1 cmd_valid", int'(cmd_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk("R1 after release", int'(pix_valid) + int'(cmd_valid) + int'(pix_data), 0);

        // R2 sweep
        fmt_sel = 2'b00;
        for (int i = 0; i < 64; i++) begin
            int v;
            v = (i == 63) ? 'h3FFFF : ((i * 4099 + 7) & 'h3FFFF);
            xfer(1'b1, v);
            chk("R2 valid", int'(pix_valid), 1);
            chk("R2 pixel", int'(pix_data), v);
        end

        // R3 sweep
        fmt_sel = 2'b01;
        for (int i = 0; i < 64; i++) begin
            int v;
            v = (i * 1021 + 3) & 'hFFFF;
            xfer(1'b1, v | 'h30000);
            chk("R3 valid", int'(pix_valid), 1);
            chk("R3 pixel", int'(pix_data), exp565(v));
        end

        // R4 sweep
        fmt_sel = 2'b10;
        for (int i = 0; i < 32; i++) begin
            int hi, lo;
            hi = (i * 37 + 1) & 511;
            lo = (i * 91 + 5) & 511;
            xfer(1'b1, hi);
            chk("R8 no pulse mid-pixel", int'(pix_valid), 0);
            xfer(1'b1, lo);
            chk("R4 valid", int'(pix_valid), 1);
            chk("R4 pixel", int'(pix_data), hi * 512 + lo);
        end

        // R5 sweep
        fmt_sel = 2'b11;
        tri_sel = 1'b0;
        for (int i = 0; i < 32; i++) begin
            int a, b;
            a = (i * 29 + 3) & 255;
            b = (i * 53 + 11) & 255;
            xfer(1'b1, a);
            chk("R8 no pulse mid-pixel", int'(pix_valid), 0);
            xfer(1'b1, b);
            chk("R5 pixel", int'(pix_data), a * 1024 + b * 4 + ((b >> 2) & 3));
        end

        // R6 sweep
        tri_sel = 1'b1;
        for (int i = 0; i < 32; i++) begin
            int a, b, c;
            a = (i * 23 + 1) & 255;
            b = (i * 41 + 7) & 255;
            c = (i * 67 + 13) & 255;
            xfer(1'b1, a);
            xfer(1'b1, b);
            chk("R8 no pulse mid-pixel", int'(pix_valid), 0);
            xfer(1'b1, c);
            chk("R6 valid", int'(pix_valid), 1);
            chk("R6 pixel", int'(pix_data), (a >> 2) * 4096 + (b >> 2) * 64 + (c >> 2));
        end

        // R7 swap in full-width and triple modes
        swap_rb = 1'b1;
        fmt_sel = 2'b00;
        for (int i = 0; i < 16; i++) begin
            int v;
            v = (i * 9973 + 1) & 'h3FFFF;
            xfer(1'b1, v);
            chk("R7 swap 18", int'(pix_data), swap_exp(v));
        end
        fmt_sel = 2'b11;
        xfer(1'b1, 'hFC);
        xfer(1'b1, 'h54);
        xfer(1'b1, 'h08);
        chk("R7 swap tri", int'(pix_data), swap_exp(63 * 4096 + 21 * 64 + 2));
        swap_rb = 1'b0;

        // R8 and R11 idle: pulse lasts one cycle, data held
        hold = int'(pix_data);
        @(negedge clk);
        bus_data = 18'h2AAAA;
        bus_dc = 1'b1;
        @(posedge clk);
        #1;
        chk("R8 single cycle pulse", int'(pix_valid), 0);
        chk("R11 pix held", int'(pix_data), hold);
        chk("R11 no cmd", int'(cmd_valid), 0);

        // R9 command writes
        for (int i = 0; i < 8; i++) begin
            int c;
            c = (i * 97 + 5) & 255;
            hold = int'(pix_data);
            xfer(1'b0, c | 'h1FF00);
            chk("R9 cmd_valid", int'(cmd_valid), 1);
            chk("R9 cmd_data", int'(cmd_data), c);
            chk("R9 no pixel", int'(pix_valid), 0);
            chk("R9 pix held", int'(pix_data), hold);
        end
        hold = int'(cmd_data);
        @(posedge clk);
        #1;
        chk("R11 cmd held", int'(cmd_data), hold);
        chk("R9 cmd one cycle", int'(cmd_valid), 0);

        // R10 command restarts packing (triple mode)
        fmt_sel = 2'b11;
        tri_sel = 1'b1;
        xfer(1'b1, 'h04);
        xfer(1'b0, 'h2C);
        xfer(1'b1, 'h80);
        xfer(1'b1, 'h40);
        chk("R10 no early pixel", int'(pix_valid), 0);
        xfer(1'b1, 'hFC);
        chk("R10 valid", int'(pix_valid), 1);
        chk("R10 pixel", int'(pix_data), 32 * 4096 + 16 * 64 + 63);

        // R10 in 9-bit mode
        fmt_sel = 2'b10;
        xfer(1'b1, 'h1FF);
        xfer(1'b0, 'h2C);
        xfer(1'b1, 'h055);
        chk("R10 9-bit restart", int'(pix_valid), 0);
        xfer(1'b1, 'h0AA);
        chk("R10 9-bit pixel", int'(pix_data), 'h055 * 512 + 'h0AA);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule